// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block walks a circular list of two-word transmit descriptors in a word-addressed memory and turns the buffers they point at into a byte stream for a MAC transmitter. Each descriptor slot sits at `ring_base + 2*index`. Its first word holds the byte address of a buffer, and its second word is a control/status word. That word gives the buffer length and marks the end of a frame. It can also suppress the CRC, mark the last slot of the ring, and carry the ownership flag. A frame may be spread over several consecutive descriptors.

Software prepares descriptors with the ownership flag clear, enables transmission and pulses `start`. The block fetches each descriptor and reads the buffer one word at a time. It sends the bytes in little-endian order over a valid/ready stream. It then rewrites the control word with the ownership flag set, and on the final buffer it adds the underrun and retry-limit reports collected from the MAC. If it meets an owned descriptor in the middle of a frame, it marks that descriptor as exhausted and aborts the frame. A halt request takes effect at the next frame boundary. `busy` shows whether the block is working.

The memory port has a fixed read latency of one cycle: read data is valid in the cycle after a request. The block gives no CRC, no line framing and no retry of collisions.

Top module: `tx_desc_ring_reader`

## Requirements
- R1: After a synchronous reset, `busy`, `tx_valid`, `tx_abort` and `mem_req` are low and the descriptor index is 0.
- R2: A `start` pulse while idle with `tx_en` high starts fetching. Word 0 of a descriptor is read at `ring_base + 2*index` and the control word at the next address. A `start` while `tx_en` is low has no effect.
- R3: A descriptor sends `ctrl[10:0]` bytes starting at the byte address in word 0, which may have any alignment. Byte k of a memory word occupies bits `8k+7:8k`. While `tx_valid` is high and `tx_ready` is low, the data, `tx_last` and `tx_nocrc` hold steady.
- R4: `tx_last` goes with the final byte of a buffer whose `ctrl[15]` is set, and with no other byte. `tx_nocrc` equals `ctrl[16]` of the descriptor supplying the byte.
- R5: Once a buffer has been sent, its control word is written back unchanged except that bit 31 is set. On the buffer with `ctrl[15]` set, bit 28 is also set if `mac_underrun` was seen during the frame, and bit 29 if `mac_retry_lim` was seen. Both reports start clear for each new frame.
- R6: A descriptor with bit 31 set, met at the start of a frame, sends nothing and writes nothing. The block goes idle and the index stays on that descriptor.
- R7: A descriptor with bit 31 set, met after a buffer without `ctrl[15]`, gets bit 27 written into it with bit 31 kept. `tx_abort` pulses for one cycle, the block goes idle and the index stays on that descriptor.
- R8: After a descriptor with `ctrl[30]` set, the next index is 0. After any other descriptor, the index goes up by one.
- R9: After a frame ends, the block goes on to the next descriptor without another `start`, provided no halt is pending and `tx_en` is high.
- R10: A `halt_req` during a frame lets that frame finish and then stops the block. A `halt_req` while idle is discarded.
- R11: While idle with `tx_en` low, the index returns to 0.
- R12: `busy` is high from the cycle after an accepted `start` until the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | AW | Word address of descriptor 0 |
| tx_en | input | 1 | Transmit enable |
| start | input | 1 | Start pulse |
| halt_req | input | 1 | Stop at the next frame boundary |
| busy | output | 1 | High while not idle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read |
| tx_valid | output | 1 | Byte available to the MAC |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_data | output | 8 | Byte to send |
| tx_last | output | 1 | Final byte of the frame |
| tx_nocrc | output | 1 | Do not append CRC to this frame |
| tx_abort | output | 1 | Frame aborted on an exhausted ring |
| mac_underrun | input | 1 | MAC reports an underrun |
| mac_retry_lim | input | 1 | MAC reports that the retry limit was exceeded |

## Verification
The assertions assume that the memory returns read data exactly one cycle after a read request. They also assume that `tx_ready` may toggle freely, and that the buffer marked as the frame end has a length of at least one. The bench memory model answers with that fixed latency, and its MAC model drops `tx_ready` on a repeating pattern. Every frame-ending buffer in the stimulus has a non-zero length. Descriptors are changed only while `busy` is low, so the block never reads a word that is being rewritten.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  localparam int unsigned LEN_W   = 11;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LANE_W  = 2;
  localparam int unsigned BIT_EOF   = 15;
  localparam int unsigned BIT_NOCRC = 16;
  localparam int unsigned BIT_EXH   = 27;
  localparam int unsigned BIT_UNDR  = 28;
  localparam int unsigned BIT_RLIM  = 29;
  localparam int unsigned BIT_WRAP  = 30;
  localparam int unsigned BIT_OWN   = 31;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH_PTR, ST_FETCH_CTL, ST_DECODE,
    ST_READ_WORD, ST_LOAD_WORD, ST_STREAM, ST_WRITEBACK, ST_EXHAUST
  } tdr_state_e;
endpackage

// File: rtl/tdr_ring_index.sv
module tdr_ring_index #(
  parameter int AW    = 10,
  parameter int IDX_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic          wrap,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] desc_addr
);
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst || clr) idx <= '0;
    else if (adv)   idx <= wrap ? '0 : idx + 1'b1;
  end

  assign desc_addr = base + AW'({idx, 1'b0});
endmodule

// File: rtl/tdr_byte_unpack.sv
module tdr_byte_unpack #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 2
) (
  input  logic [WORD_W-1:0] word,
  input  logic [LANE_W-1:0] lane,
  output logic [7:0]        byte_out
);
  localparam int NLANE = WORD_W / 8;
  logic [7:0] lanes [NLANE];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lanes[g] = word[8*g +: 8];
  end

  assign byte_out = lanes[lane];
endmodule

// File: rtl/tdr_err_sticky.sv
module tdr_err_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] flags
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || clr)  flags[g] <= 1'b0;
      else if (set[g]) flags[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_desc_ring_reader.sv
module tx_desc_ring_reader
  import tdr_pkg::*;
#(
  parameter int AW    = 10,
  parameter int IDX_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ring_base,
  input  logic          tx_en,
  input  logic          start,
  input  logic          halt_req,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          tx_nocrc,
  output logic          tx_abort,
  input  logic          mac_underrun,
  input  logic          mac_retry_lim
);
  localparam logic [LANE_W-1:0] LANE_MAX = '1;

  tdr_state_e        state;
  logic [AW-1:0]     desc_addr;
  logic [AW-1:0]     buf_wptr;
  logic [LANE_W-1:0] lane;
  logic [LEN_W-1:0]  remain;
  logic [WORD_W-1:0] ctrl_q;
  logic [WORD_W-1:0] word_q;
  logic              in_frame;
  logic              halt_pend;
  logic [1:0]        err_flags;
  logic              err_clr;
  logic              idx_adv;
  logic              idx_clr;
  logic [WORD_W-1:0] wb_word;

  assign idx_adv = (state == ST_WRITEBACK);
  assign idx_clr = (state == ST_IDLE) && !tx_en;
  assign err_clr = (state == ST_DECODE) && !in_frame && !mem_rdata[BIT_OWN];

  tdr_ring_index #(.AW(AW), .IDX_W(IDX_W)) u_index (
    .clk      (clk),
    .rst      (rst),
    .clr      (idx_clr),
    .adv      (idx_adv),
    .wrap     (ctrl_q[BIT_WRAP]),
    .base     (ring_base),
    .desc_addr(desc_addr)
  );

  tdr_byte_unpack #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_unpack (
    .word    (word_q),
    .lane    (lane),
    .byte_out(tx_data)
  );

  tdr_err_sticky #(.N(2)) u_err (
    .clk  (clk),
    .rst  (rst),
    .clr  (err_clr),
    .set  ({mac_retry_lim, mac_underrun} & {2{busy}}),
    .flags(err_flags)
  );

  always_comb begin
    wb_word = ctrl_q;
    wb_word[BIT_OWN] = 1'b1;
    if (ctrl_q[BIT_EOF]) begin
      wb_word[BIT_UNDR] = ctrl_q[BIT_UNDR] | err_flags[0];
      wb_word[BIT_RLIM] = ctrl_q[BIT_RLIM] | err_flags[1];
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = '0;
    unique case (state)
      ST_FETCH_PTR: mem_req = 1'b1;
      ST_FETCH_CTL: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'(1);
      end
      ST_READ_WORD: begin
        mem_req  = 1'b1;
        mem_addr = buf_wptr;
      end
      ST_WRITEBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + AW'(1);
        mem_wdata = wb_word;
      end
      ST_EXHAUST: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + AW'(1);
        mem_wdata = ctrl_q | (WORD_W'(1) << BIT_EXH);
      end
      default: ;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign tx_valid = (state == ST_STREAM);
  assign tx_last  = (state == ST_STREAM) && ctrl_q[BIT_EOF] && (remain == LEN_W'(1));
  assign tx_nocrc = ctrl_q[BIT_NOCRC];
  assign tx_abort = (state == ST_EXHAUST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      buf_wptr  <= '0;
      lane      <= '0;
      remain    <= '0;
      ctrl_q    <= '0;
      word_q    <= '0;
      in_frame  <= 1'b0;
      halt_pend <= 1'b0;
    end else begin
      if (state == ST_IDLE) halt_pend <= 1'b0;
      else if (halt_req)    halt_pend <= 1'b1;

      unique case (state)
        ST_IDLE: if (start && tx_en) state <= ST_FETCH_PTR;
        ST_FETCH_PTR: state <= ST_FETCH_CTL;
        ST_FETCH_CTL: begin
          buf_wptr <= mem_rdata[AW+1:2];
          lane     <= mem_rdata[LANE_W-1:0];
          state    <= ST_DECODE;
        end
        ST_DECODE: begin
          ctrl_q <= mem_rdata;
          remain <= mem_rdata[LEN_W-1:0];
          if (mem_rdata[BIT_OWN])
            state <= in_frame ? ST_EXHAUST : ST_IDLE;
          else if (mem_rdata[LEN_W-1:0] == '0)
            state <= ST_WRITEBACK;
          else
            state <= ST_READ_WORD;
        end
        ST_READ_WORD: state <= ST_LOAD_WORD;
        ST_LOAD_WORD: begin
          word_q <= mem_rdata;
          state  <= ST_STREAM;
        end
        ST_STREAM: if (tx_ready) begin
          remain <= remain - 1'b1;
          lane   <= lane + 1'b1;
          if (remain == LEN_W'(1)) begin
            state <= ST_WRITEBACK;
          end else if (lane == LANE_MAX) begin
            buf_wptr <= buf_wptr + 1'b1;
            state    <= ST_READ_WORD;
          end
        end
        ST_WRITEBACK: begin
          if (ctrl_q[BIT_EOF]) begin
            in_frame <= 1'b0;
            if (halt_pend || halt_req || !tx_en) state <= ST_IDLE;
            else                                 state <= ST_FETCH_PTR;
          end else begin
            in_frame <= 1'b1;
            state    <= ST_FETCH_PTR;
          end
        end
        ST_EXHAUST: begin
          in_frame <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tdr_chk.sv
module tdr_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_en,
  input logic          start,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic [31:0]   mem_wdata,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          tx_nocrc,
  input logic          tx_abort
);
  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_nocrc));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req && !tx_valid && !tx_abort);

  // R12
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !busy && start && tx_en |=> busy);

  // R2
  no_en_start_chk: assert property (@(posedge clk) disable iff (rst)
    !busy && start && !tx_en |=> !busy);

  // R5
  wb_owned_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_wdata[31]);

  // R7
  abort_wr_chk: assert property (@(posedge clk) disable iff (rst)
    tx_abort |-> mem_req && mem_we && mem_wdata[27] && !tx_valid);

  // R7
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    tx_abort |=> !busy && !tx_abort);
endmodule

bind tx_desc_ring_reader tdr_chk #(.AW(AW)) u_chk (.*);

// File: tb/tx_desc_ring_reader_tb.sv
module tx_desc_ring_reader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int IDX_W = 3;
  localparam int MEM_WORDS = 1 << AW;
  localparam logic [31:0] EOFB  = 32'h0000_8000;
  localparam logic [31:0] NOCRC = 32'h0001_0000;
  localparam logic [31:0] EXH   = 32'h0800_0000;
  localparam logic [31:0] UNDR  = 32'h1000_0000;
  localparam logic [31:0] RLIM  = 32'h2000_0000;
  localparam logic [31:0] WRAPB = 32'h4000_0000;
  localparam logic [31:0] OWN   = 32'h8000_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic tx_en = 1'b0, start = 1'b0, halt_req = 1'b0;
  logic busy, mem_req, mem_we, tx_valid, tx_last, tx_nocrc, tx_abort;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic mac_underrun = 1'b0, mac_retry_lim = 1'b0;

  logic [31:0] mem [MEM_WORDS];
  logic tb_we = 1'b0;
  logic [AW-1:0] tb_addr = '0;
  logic [31:0] tb_data = '0;
  int wr_cnt = 0, abort_cnt = 0, cyc = 0;
  int cap_n = 0;
  logic [7:0] cap_d [1024];
  logic cap_l [1024];
  logic cap_c [1024];
  int exp_n;
  logic [7:0] exp_d [64];
  logic exp_l [64];
  logic exp_c [64];
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_desc_ring_reader #(.AW(AW), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst), .ring_base('0), .tx_en(tx_en), .start(start),
    .halt_req(halt_req), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_nocrc(tx_nocrc), .tx_abort(tx_abort),
    .mac_underrun(mac_underrun), .mac_retry_lim(mac_retry_lim));

  function automatic logic [7:0] pat(input int b);
    return 8'((b * 7 + 3) & 255);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < MEM_WORDS; w++)
        mem[w] <= (w < 16) ? OWN : {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
      mem_rdata <= '0;
    end else begin
      if (tb_we) mem[tb_addr] <= tb_data;
      if (mem_req && mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (mem_req) mem_rdata <= mem[mem_addr];
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tx_ready = (cyc % 5) != 2;
    if (tx_valid && tx_ready) begin
      cap_d[cap_n] <= tx_data;
      cap_l[cap_n] <= tx_last;
      cap_c[cap_n] <= tx_nocrc;
      cap_n <= cap_n + 1;
    end
    if (tx_abort) abort_cnt <= abort_cnt + 1;
    if (cyc == 150000) begin
      $display("FAIL watchdog: actual run still going, expected finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, expv);
    end
  endtask

  task automatic mw(input int a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = AW'(a); tb_data = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic set_desc(input int i, input int buf_addr, input logic [31:0] ctrl);
    mw(2*i, 32'(buf_addr));
    mw(2*i+1, ctrl);
  endtask

  task automatic idx_home;
    @(negedge clk); tx_en = 1'b0;
    @(negedge clk); @(negedge clk); tx_en = 1'b1;
  endtask

  task automatic kick;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R12 busy after start", longint'(busy), 1);
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
    check(busy == 1'b0, "R12 busy returns low", longint'(busy), 0);
    @(negedge clk);
  endtask

  task automatic add_exp(input int buf_addr, input int len, input bit eof, input bit nc);
    for (int k = 0; k < len; k++) begin
      exp_d[exp_n] = pat(buf_addr + k);
      exp_l[exp_n] = eof && (k == len - 1);
      exp_c[exp_n] = nc;
      exp_n++;
    end
  endtask

  task automatic cmp_frame(input int from, input string what);
    int bad;
    bad = -1;
    for (int k = 0; k < exp_n; k++)
      if (bad < 0 && (cap_d[from+k] !== exp_d[k] || cap_l[from+k] !== exp_l[k] ||
                      cap_c[from+k] !== exp_c[k])) bad = k;
    check(cap_n - from == exp_n, {what, " byte count"}, cap_n - from, exp_n);
    if (bad >= 0)
      check(1'b0, {what, " byte content"}, {cap_c[from+bad], cap_l[from+bad], cap_d[from+bad]},
            {exp_c[bad], exp_l[bad], exp_d[bad]});
    else
      check(1'b1, what, 0, 0);
  endtask

  initial begin
    int from, w0, a0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !tx_valid && !mem_req && !tx_abort, "R1 reset outputs",
          {busy, tx_valid, mem_req, tx_abort}, 0);
    tx_en = 1'b1;

    // R3 R4 R5 sweep of alignment and length
    for (int off = 0; off < 4; off++) begin
      for (int len = 1; len <= 9; len++) begin
        a0 = 32'h400 + 32 * (off * 9 + len) + off;
        idx_home();
        set_desc(0, a0, 32'(len) | EOFB);
        from = cap_n; exp_n = 0;
        add_exp(a0, len, 1'b1, 1'b0);
        kick();
        cmp_frame(from, "R3 R4 sweep frame");
        check(mem[1] == (32'(len) | EOFB | OWN), "R5 writeback", mem[1], 32'(len) | EOFB | OWN);
      end
    end

    // R4 frame over three descriptors, per-descriptor no-CRC flag
    idx_home();
    set_desc(0, 32'h802, 32'd3 | NOCRC);
    set_desc(1, 32'h905, 32'd6);
    set_desc(2, 32'hA00, 32'd4 | EOFB | NOCRC);
    from = cap_n; exp_n = 0;
    add_exp(32'h802, 3, 1'b0, 1'b1);
    add_exp(32'h905, 6, 1'b0, 1'b0);
    add_exp(32'hA00, 4, 1'b1, 1'b1);
    kick();
    cmp_frame(from, "R4 multi-buffer frame");
    check(mem[1] == (32'd3 | NOCRC | OWN), "R5 first buffer writeback", mem[1], 32'd3 | NOCRC | OWN);
    check(mem[3] == (32'd6 | OWN), "R5 middle buffer writeback", mem[3], 32'd6 | OWN);

    // R6 owned descriptor at frame start
    idx_home();
    set_desc(0, 32'hB00, 32'd5 | EOFB | OWN);
    from = cap_n; w0 = wr_cnt;
    kick();
    check(cap_n == from, "R6 no bytes", cap_n - from, 0);
    check(wr_cnt == w0, "R6 no writeback", wr_cnt - w0, 0);
    mw(1, 32'd5 | EOFB);
    exp_n = 0; add_exp(32'hB00, 5, 1'b1, 1'b0);
    kick();
    cmp_frame(from, "R6 index kept");

    // R7 exhaustion in the middle of a frame
    idx_home();
    set_desc(0, 32'hC00, 32'd4);
    set_desc(1, 32'hC40, 32'd3 | OWN);
    from = cap_n; w0 = abort_cnt;
    exp_n = 0; add_exp(32'hC00, 4, 1'b0, 1'b0);
    kick();
    cmp_frame(from, "R7 partial frame");
    check(abort_cnt == w0 + 1, "R7 abort pulse", abort_cnt - w0, 1);
    check(mem[3] == (32'd3 | OWN | EXH), "R7 exhausted flag", mem[3], 32'd3 | OWN | EXH);
    check(mem[1] == (32'd4 | OWN), "R7 sent buffer owned", mem[1], 32'd4 | OWN);
    mw(3, 32'd2 | EOFB);
    from = cap_n; exp_n = 0; add_exp(32'hC40, 2, 1'b1, 1'b0);
    kick();
    cmp_frame(from, "R7 index kept");

    // R8 R9 wrap and back-to-back frames
    idx_home();
    set_desc(0, 32'hD00, 32'd2 | EOFB);
    set_desc(1, 32'hD10, 32'd2 | EOFB);
    set_desc(2, 32'hD20, 32'd2 | EOFB | WRAPB);
    from = cap_n; exp_n = 0;
    add_exp(32'hD00, 2, 1'b1, 1'b0);
    add_exp(32'hD10, 2, 1'b1, 1'b0);
    add_exp(32'hD20, 2, 1'b1, 1'b0);
    kick();
    cmp_frame(from, "R9 continuous frames");
    check(mem[5] == (32'd2 | EOFB | WRAPB | OWN), "R8 wrap descriptor writeback", mem[5],
          32'd2 | EOFB | WRAPB | OWN);
    set_desc(0, 32'hD31, 32'd3 | EOFB);
    from = cap_n; exp_n = 0; add_exp(32'hD31, 3, 1'b1, 1'b0);
    kick();
    cmp_frame(from, "R8 back at ring base");

    // R5 underrun and retry-limit reports
    idx_home();
    set_desc(0, 32'hE00, 32'd6 | EOFB);
    set_desc(1, 32'hE00, 32'd1 | EOFB | OWN);
    fork
      kick();
      begin
        wait (tx_valid);
        @(negedge clk); mac_underrun = 1'b1;
        @(negedge clk); mac_underrun = 1'b0;
      end
    join
    check(mem[1] == (32'd6 | EOFB | OWN | UNDR), "R5 underrun bit", mem[1], 32'd6 | EOFB | OWN | UNDR);
    idx_home();
    set_desc(0, 32'hE00, 32'd6 | EOFB);
    fork
      kick();
      begin
        wait (tx_valid);
        @(negedge clk); mac_retry_lim = 1'b1;
        @(negedge clk); mac_retry_lim = 1'b0;
      end
    join
    check(mem[1] == (32'd6 | EOFB | OWN | RLIM), "R5 retry bit, underrun cleared", mem[1],
          32'd6 | EOFB | OWN | RLIM);

    // R10 halt during a frame, then halt while idle
    idx_home();
    set_desc(0, 32'hF00, 32'd8 | EOFB);
    set_desc(1, 32'hF20, 32'd3 | EOFB);
    set_desc(2, 32'hF40, 32'd1 | EOFB | OWN);
    from = cap_n; exp_n = 0; add_exp(32'hF00, 8, 1'b1, 1'b0);
    fork
      kick();
      begin
        wait (tx_valid);
        @(negedge clk); halt_req = 1'b1;
        check(busy == 1'b1, "R10 busy while frame finishes", busy, 1);
        @(negedge clk); halt_req = 1'b0;
      end
    join
    cmp_frame(from, "R10 frame completes");
    check(mem[3] == (32'd3 | EOFB), "R10 next descriptor untouched", mem[3], 32'd3 | EOFB);
    @(negedge clk); halt_req = 1'b1;
    @(negedge clk); halt_req = 1'b0;
    from = cap_n; exp_n = 0; add_exp(32'hF20, 3, 1'b1, 1'b0);
    kick();
    cmp_frame(from, "R10 idle halt discarded");

    // R2 start ignored while transmit disabled
    idx_home();
    set_desc(0, 32'hF81, 32'd2 | EOFB);
    @(negedge clk); tx_en = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    from = cap_n;
    repeat (10) @(negedge clk);
    check(!busy && cap_n == from, "R2 start with tx_en low", {busy, 8'(cap_n - from)}, 0);
    tx_en = 1'b1;
    exp_n = 0; add_exp(32'hF81, 2, 1'b1, 1'b0);
    kick();
    cmp_frame(from, "R2 start with tx_en high");

    // R11 index returns to base while disabled (index now 1, descriptor 1 owned)
    set_desc(0, 32'hF93, 32'd5 | EOFB);
    idx_home();
    from = cap_n; exp_n = 0; add_exp(32'hF93, 5, 1'b1, 1'b0);
    kick();
    cmp_frame(from, "R11 index reset");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule